// File: doc/BRIEF.md
# Vector Reduction Element Sequencer

This block breaks a single vector instruction into its element operations. It issues them one per accepted handshake. The destination can be a full vector or a scalar accumulator.

A start pulse latches the following:
- the element count and the sub-vector length;
- the mode flags;
- three base register indices.

From then on the block presents one issue at a time. Each issue carries the element index, the sub-element index, the destination offset and a last flag, and is paced by `iss_valid` / `iss_ready`.

Each accepted issue also performs one 16-bit addition inside a small register array. The array has a load port and a read port, so the effect of every ordering can be observed. When a scalar destination is set without map-reduce, the loop stops after its first element. With map-reduce set, the loop carries on across every element and folds each one into the accumulator. Reverse gear walks the elements from the top down. Horizontal mode sums the sub-elements of each element into one result.

Operand addresses are base plus offset, modulo `NREGS`. Element `e`, sub-element `s` of a vector sits at offset `k = e*SV + s`, where `SV` is the sub-vector length.

Top module: `vred_seq_top`

## Requirements
- R1: After reset, `iss_valid` and `seq_done` are both 0.
- R2: With a vector destination, `src_a_scalar`=0 and horizontal mode inactive, the block issues all `VL*SV` operations. The element index ascends in the outer loop and the sub-element index ascends in the inner loop. Each issue writes reg[dst+k] = reg[a+k] + reg[b+k], and `iss_dst_off` equals k.
- R3: With `dst_scalar`=1, `map_reduce`=0 and horizontal mode inactive, only the first element in loop order is issued, with all of its sub-elements. Each issue writes reg[dst+s] = reg[a+s] + reg[b+k], and `iss_dst_off` equals s.
- R4: With `dst_scalar`=1 and `map_reduce`=1, all VL elements are issued. Each sub-element lane s accumulates independently: reg[dst+s] = reg[a+s] + reg[b+k]. With the a base equal to the dst base, this is a running sum.
- R5: With `reverse`=1, the element index runs from VL-1 down to 0, and the sub-element index still ascends. This holds for vector and scalar destinations alike, so overlapping vector operands form a cumulative series taken from the top.
- R6: Horizontal mode is active when `horizontal`=1 and SV>1. Each element then yields one result at offset e (`iss_dst_off`=e). The issue for s=0 writes reg[dst+e] = reg[b+k]. Each later sub-element writes reg[dst+e] = reg[dst+e] + reg[b+k]. With SV=1 the flag has no effect.
- R7: A start with VL=0 issues nothing. `seq_done` is 1 in the cycle after the start edge.
- R8: While `iss_valid`=1 and `iss_ready`=0, every issue output holds its value. The sequence advances only on a cycle with both high.
- R9: `iss_last` is 1 only on the final issue. After that handshake, `seq_done` pulses for one cycle and `iss_valid` drops.
- R10: A start pulse that arrives while a sequence is running is ignored: the running sequence and its results are unchanged.
- R11: With `src_a_scalar`=1 and a vector destination, the a operand of each issue is reg[a+s], with no element term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches a sequence when idle |
| vec_len | input | VL_W | Element count VL |
| sub_len | input | SUB_W+1 | Sub-vector length, binary 1..SUBVL_MAX |
| map_reduce | input | 1 | Keep issuing with a scalar destination |
| reverse | input | 1 | Walk elements from VL-1 downward |
| horizontal | input | 1 | Reduce across the sub-elements of each element |
| dst_scalar | input | 1 | Destination is a scalar accumulator |
| src_a_scalar | input | 1 | The a operand is scalar |
| base_dst | input | AW | Destination base register |
| base_a | input | AW | Base register of the a operand |
| base_b | input | AW | Base register of the b (vector) operand |
| iss_valid | output | 1 | An issue is presented |
| iss_ready | input | 1 | The consumer accepts the issue |
| iss_elem | output | VL_W | Element index |
| iss_sub | output | SUB_W | Sub-element index |
| iss_dst_off | output | AW | Destination register offset |
| iss_last | output | 1 | Final issue of the sequence |
| seq_done | output | 1 | One-cycle pulse at sequence end |
| ld_en | input | 1 | Register load strobe (idle only) |
| ld_addr | input | AW | Register load address |
| ld_data | input | DATA_W | Register load data |
| rd_addr | input | AW | Register read address |
| rd_data | output | DATA_W | Register read data (combinational) |

## Verification
The assertions take for granted that `sub_len` lies between 1 and SUBVL_MAX on every start. They also assume `iss_ready` is a plain level that depends on nothing but the consumer. The stimulus therefore only drives lengths from 1 to 4. It draws `iss_ready` freshly on each falling edge, either held high or randomly low about a third of the time, and this exercises the hold rule. Register loads take place only while the block is idle. The second start, sent during a running sequence, carries a deliberately different configuration, so any leak into the running sequence would show at once.

// File: rtl/vred_pkg.sv
`timescale 1ns/1ps
package vred_pkg;
   typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;

   typedef struct packed {
      logic map_red;
      logic rev;
      logic horiz;
      logic dst_scalar;
      logic a_scalar;
   } seq_mode_t;
endpackage

// File: rtl/vred_ctrl.sv
`timescale 1ns/1ps
module vred_ctrl
   import vred_pkg::*;
#(
   parameter int VL_W  = 4,
   parameter int SUB_W = 2,
   localparam int SV_W = SUB_W + 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [VL_W-1:0]  vec_len,
   input  logic [SV_W-1:0]  sub_len,
   input  seq_mode_t        mode_in,
   input  logic             ready,
   output logic             accept,
   output logic             valid,
   output logic [VL_W-1:0]  elem,
   output logic [SUB_W-1:0] sub,
   output logic             last,
   output logic             done,
   output seq_mode_t        mode,
   output logic [SV_W-1:0]  sv,
   output logic             hz_act
);
   seq_state_e       st;
   seq_mode_t        md;
   logic [VL_W-1:0]  vl_q, elem_q, cnt_q, n_elem;
   logic [SV_W-1:0]  sv_q;
   logic [SUB_W-1:0] sub_q;
   logic             done_q, last_sub, last_elem, fire;

   assign accept    = (st == SEQ_IDLE) && start;
   assign valid     = (st == SEQ_RUN);
   assign hz_act    = md.horiz && (sv_q > SV_W'(1));
   assign n_elem    = (md.dst_scalar && !md.map_red && !hz_act) ? VL_W'(1) : vl_q;
   assign last_sub  = (SV_W'(sub_q) + SV_W'(1)) == sv_q;
   assign last_elem = (cnt_q + VL_W'(1)) == n_elem;
   assign last      = valid && last_sub && last_elem;
   assign fire      = valid && ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SEQ_IDLE;
         md     <= '0;
         vl_q   <= '0;
         sv_q   <= SV_W'(1);
         elem_q <= '0;
         cnt_q  <= '0;
         sub_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st)
            SEQ_IDLE: if (start) begin
               md   <= mode_in;
               vl_q <= vec_len;
               sv_q <= sub_len;
               if (vec_len == '0) begin
                  done_q <= 1'b1;
               end else begin
                  st     <= SEQ_RUN;
                  elem_q <= mode_in.rev ? (vec_len - VL_W'(1)) : '0;
                  cnt_q  <= '0;
                  sub_q  <= '0;
               end
            end
            SEQ_RUN: if (fire) begin
               if (last) begin
                  st     <= SEQ_IDLE;
                  done_q <= 1'b1;
               end else if (last_sub) begin
                  sub_q  <= '0;
                  cnt_q  <= cnt_q + VL_W'(1);
                  elem_q <= md.rev ? (elem_q - VL_W'(1)) : (elem_q + VL_W'(1));
               end else begin
                  sub_q <= sub_q + SUB_W'(1);
               end
            end
            default: st <= SEQ_IDLE;
         endcase
      end
   end

   assign elem = elem_q;
   assign sub  = sub_q;
   assign done = done_q;
   assign mode = md;
   assign sv   = sv_q;

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !ready |=> valid && $stable(elem_q) && $stable(sub_q) && $stable(last));

   assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
      valid && ready && last |=> done && !valid);

   assert_empty_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (vec_len == '0) |=> done && !valid);

   assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      valid && start && !(ready && last) |=> valid && $stable(md) && $stable(vl_q));

   assert_single_element_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid && md.dst_scalar && !md.map_red && !hz_act |-> cnt_q == '0);

   assert_sub_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> SV_W'(sub_q) < sv_q);
endmodule

// File: rtl/vred_agen.sv
`timescale 1ns/1ps
module vred_agen
   import vred_pkg::*;
#(
   parameter int VL_W  = 4,
   parameter int SUB_W = 2,
   parameter int AW    = 6,
   localparam int SV_W  = SUB_W + 1,
   localparam int OFF_W = VL_W + SV_W
)(
   input  logic [VL_W-1:0]  elem,
   input  logic [SUB_W-1:0] sub,
   input  logic [SV_W-1:0]  sv,
   input  seq_mode_t        mode,
   input  logic             hz_act,
   input  logic [AW-1:0]    base_dst,
   input  logic [AW-1:0]    base_a,
   input  logic [AW-1:0]    base_b,
   output logic [AW-1:0]    dst_off,
   output logic [AW-1:0]    dst_addr,
   output logic [AW-1:0]    a_addr,
   output logic [AW-1:0]    b_addr,
   output logic             a_zero
);
   logic [OFF_W-1:0] k;
   logic [AW-1:0]    k_a, s_a, e_a;

   always_comb begin
      k   = OFF_W'(elem) * OFF_W'(sv) + OFF_W'(sub);
      k_a = AW'(k);
      s_a = AW'(sub);
      e_a = AW'(elem);
      a_zero = 1'b0;
      if (hz_act) begin
         dst_off = e_a;
         a_addr  = base_dst + e_a;
         a_zero  = (sub == '0);
      end else if (mode.dst_scalar) begin
         dst_off = s_a;
         a_addr  = base_a + s_a;
      end else begin
         dst_off = k_a;
         a_addr  = mode.a_scalar ? (base_a + s_a) : (base_a + k_a);
      end
      dst_addr = base_dst + dst_off;
      b_addr   = base_b + k_a;
   end
endmodule

// File: rtl/vred_exec.sv
`timescale 1ns/1ps
module vred_exec #(
   parameter int NREGS  = 64,
   parameter int DATA_W = 16,
   localparam int AW    = $clog2(NREGS)
)(
   input  logic              clk,
   input  logic              fire,
   input  logic              busy,
   input  logic [AW-1:0]     dst_addr,
   input  logic [AW-1:0]     a_addr,
   input  logic [AW-1:0]     b_addr,
   input  logic              a_zero,
   input  logic              ld_en,
   input  logic [AW-1:0]     ld_addr,
   input  logic [DATA_W-1:0] ld_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] rf [NREGS];
   logic [DATA_W-1:0] opa, sum;
   logic              we;
   logic [AW-1:0]     wa;
   logic [DATA_W-1:0] wd;

   assign opa = a_zero ? '0 : rf[a_addr];
   assign sum = opa + rf[b_addr];
   assign we  = fire || (ld_en && !busy);
   assign wa  = fire ? dst_addr : ld_addr;
   assign wd  = fire ? sum : ld_data;

   always_ff @(posedge clk) begin
      if (we) rf[wa] <= wd;
   end

   assign rd_data = rf[rd_addr];

   assert_no_load_clash_R2: assert property (@(posedge clk)
      fire |-> busy);
endmodule

// File: rtl/vred_seq_top.sv
`timescale 1ns/1ps
module vred_seq_top
   import vred_pkg::*;
#(
   parameter int VL_W      = 4,
   parameter int SUBVL_MAX = 4,
   parameter int NREGS     = 64,
   parameter int DATA_W    = 16,
   localparam int SUB_W = (SUBVL_MAX > 1) ? $clog2(SUBVL_MAX) : 1,
   localparam int SV_W  = SUB_W + 1,
   localparam int AW    = $clog2(NREGS)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [VL_W-1:0]   vec_len,
   input  logic [SV_W-1:0]   sub_len,
   input  logic              map_reduce,
   input  logic              reverse,
   input  logic              horizontal,
   input  logic              dst_scalar,
   input  logic              src_a_scalar,
   input  logic [AW-1:0]     base_dst,
   input  logic [AW-1:0]     base_a,
   input  logic [AW-1:0]     base_b,
   output logic              iss_valid,
   input  logic              iss_ready,
   output logic [VL_W-1:0]   iss_elem,
   output logic [SUB_W-1:0]  iss_sub,
   output logic [AW-1:0]     iss_dst_off,
   output logic              iss_last,
   output logic              seq_done,
   input  logic              ld_en,
   input  logic [AW-1:0]     ld_addr,
   input  logic [DATA_W-1:0] ld_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   if (SUBVL_MAX < 1 || SUBVL_MAX > 4) begin : g_bad_subvl
      $error("SUBVL_MAX must lie in 1..4");
   end
   if (NREGS < 2 || (NREGS & (NREGS - 1)) != 0) begin : g_bad_nregs
      $error("NREGS must be a power of two of at least 2");
   end
   if (VL_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("VL_W and DATA_W must be positive");
   end

   seq_mode_t        mode_in, mode;
   logic             accept, hz_act;
   logic [SV_W-1:0]  sv;
   logic [AW-1:0]    bd_q, ba_q, bb_q;
   logic [AW-1:0]    dst_addr, a_addr, b_addr;
   logic             a_zero;

   assign mode_in = '{map_red: map_reduce, rev: reverse, horiz: horizontal,
                      dst_scalar: dst_scalar, a_scalar: src_a_scalar};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bd_q <= '0;
         ba_q <= '0;
         bb_q <= '0;
      end else if (accept) begin
         bd_q <= base_dst;
         ba_q <= base_a;
         bb_q <= base_b;
      end
   end

   vred_ctrl #(.VL_W(VL_W), .SUB_W(SUB_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .vec_len (vec_len),
      .sub_len (sub_len),
      .mode_in (mode_in),
      .ready   (iss_ready),
      .accept  (accept),
      .valid   (iss_valid),
      .elem    (iss_elem),
      .sub     (iss_sub),
      .last    (iss_last),
      .done    (seq_done),
      .mode    (mode),
      .sv      (sv),
      .hz_act  (hz_act)
   );

   vred_agen #(.VL_W(VL_W), .SUB_W(SUB_W), .AW(AW)) u_agen (
      .elem     (iss_elem),
      .sub      (iss_sub),
      .sv       (sv),
      .mode     (mode),
      .hz_act   (hz_act),
      .base_dst (bd_q),
      .base_a   (ba_q),
      .base_b   (bb_q),
      .dst_off  (iss_dst_off),
      .dst_addr (dst_addr),
      .a_addr   (a_addr),
      .b_addr   (b_addr),
      .a_zero   (a_zero)
   );

   vred_exec #(.NREGS(NREGS), .DATA_W(DATA_W)) u_exec (
      .clk      (clk),
      .fire     (iss_valid && iss_ready),
      .busy     (iss_valid),
      .dst_addr (dst_addr),
      .a_addr   (a_addr),
      .b_addr   (b_addr),
      .a_zero   (a_zero),
      .ld_en    (ld_en),
      .ld_addr  (ld_addr),
      .ld_data  (ld_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data)
   );

   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iss_valid) |-> $past(start));
endmodule

// File: tb/vred_seq_top_test.sv
`timescale 1ns/1ps
module vred_seq_top_test;
   localparam int N = 64;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        start = 0, map_reduce = 0, reverse = 0, horizontal = 0;
   logic        dst_scalar = 0, src_a_scalar = 0, iss_ready = 1, ld_en = 0;
   logic [3:0]  vec_len = 0;
   logic [2:0]  sub_len = 1;
   logic [5:0]  base_dst = 0, base_a = 0, base_b = 0, ld_addr = 0, rd_addr = 0;
   logic [15:0] ld_data = 0;
   logic        iss_valid, iss_last, seq_done;
   logic [3:0]  iss_elem;
   logic [1:0]  iss_sub;
   logic [5:0]  iss_dst_off;
   logic [15:0] rd_data;

   int checks = 0, errors = 0;
   logic [15:0] m [N];
   logic [12:0] exp_q [$];
   bit          bp = 0;
   string       cur_req = "R2";

   vred_seq_top uut (.*);

   always #2.5 clk = ~clk;

   always @(negedge clk) iss_ready <= bp ? (($urandom % 3) != 0) : 1'b1;

   // monitor: scoreboard pop and hold check, 0.5 ns before the active edge
   logic        held = 0;
   logic [12:0] held_v;
   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         if (held) begin
            checks++;
            if (!iss_valid || {iss_elem, iss_sub, iss_dst_off, iss_last} != held_v) begin
               errors++;
               $display("FAIL R8 hold: actual %h expected %h", {iss_elem, iss_sub, iss_dst_off, iss_last}, held_v);
            end
         end
         held = iss_valid && !iss_ready;
         held_v = {iss_elem, iss_sub, iss_dst_off, iss_last};
         if (iss_valid && iss_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL %s extra issue: actual %h expected none", cur_req, held_v);
            end else begin
               logic [12:0] e;
               e = exp_q.pop_front();
               if (e != held_v) begin
                  errors++;
                  $display("FAIL %s/R9 issue: actual %h expected %h", cur_req, held_v, e);
               end
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // driver: builds the expected issue list and register effects, then launches
   task automatic run_case(input string req, input int vl, input int sv, input bit mr,
                           input bit rv, input bit hz, input bit ds, input bit as,
                           input int rt, input int ra, input int rb, input bit bpm,
                           input bit poke);
      bit hza;
      int n_el, iters;
      hza = hz && sv > 1;
      n_el = (ds && !mr && !hza) ? 1 : vl;
      for (int c = 0; c < n_el; c++) begin
         int e;
         e = rv ? vl - 1 - c : c;
         for (int s = 0; s < sv; s++) begin
            int k, off;
            logic [15:0] a;
            k = e * sv + s;
            if (hza) begin
               off = e;
               a = (s == 0) ? 16'd0 : m[(rt + e) % N];
            end else if (ds) begin
               off = s;
               a = m[(ra + s) % N];
            end else begin
               off = k % N;
               a = as ? m[(ra + s) % N] : m[(ra + k) % N];
            end
            m[(rt + off) % N] = a + m[(rb + k) % N];
            exp_q.push_back({4'(e), 2'(s), 6'(off), (c == n_el - 1) && (s == sv - 1)});
         end
      end
      @(negedge clk);
      cur_req = req; bp = bpm;
      vec_len = 4'(vl); sub_len = 3'(sv); map_reduce = mr; reverse = rv;
      horizontal = hz; dst_scalar = ds; src_a_scalar = as;
      base_dst = 6'(rt); base_a = 6'(ra); base_b = 6'(rb);
      start = 1;
      iters = 0;
      while (iters < 600) begin
         @(negedge clk);
         iters++;
         start = 0;
         if (poke && iters == 3) begin   // R10: a foreign start mid-run
            start = 1; vec_len = 4'd2; sub_len = 3'd1; reverse = ~rv;
            dst_scalar = ~ds; base_dst = 6'd63; base_b = 6'd0;
         end
         #2;
         if (seq_done) break;
      end
      check(seq_done, {req, "/R9 done seen"}, seq_done, 1);
      check(!iss_valid, {req, "/R9 idle after done"}, iss_valid, 0);
      check(exp_q.size() == 0, {req, "/R9 all issued"}, exp_q.size(), 0);
      if (vl == 0) check(iters == 1, "R7 done latency", iters, 1);
      exp_q.delete();
      bp = 0;
      begin
         int bad;
         bad = -1;
         for (int r = 0; r < N; r++) begin
            @(negedge clk); rd_addr = 6'(r); #1;
            if (rd_data !== m[r] && bad < 0) bad = r;
         end
         checks++;
         if (bad >= 0) begin
            errors++;
            $display("FAIL %s regfile[%0d]: actual %0d expected %0d", req, bad, uut.rd_data, m[bad]);
         end
      end
   endtask

   initial begin
      fork
         begin
            repeat (100000) @(posedge clk);
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      join_none
      repeat (3) @(negedge clk);
      rst_n = 1;
      #2;
      check(!iss_valid, "R1 valid after reset", iss_valid, 0);
      check(!seq_done, "R1 done after reset", seq_done, 0);
      for (int r = 0; r < N; r++) begin
         @(negedge clk);
         ld_en = 1; ld_addr = 6'(r); ld_data = 16'(r * 7 + 3); m[r] = 16'(r * 7 + 3);
      end
      @(negedge clk); ld_en = 0;
      //       req    vl sv mr rv hz ds as rt  ra  rb  bp poke
      run_case("R2",   5, 1, 0, 0, 0, 0, 0, 40, 10, 20, 0, 0);
      run_case("R2",   4, 2, 0, 0, 0, 0, 0, 30,  2, 12, 1, 0);
      run_case("R3",   6, 1, 0, 0, 0, 1, 0, 50, 50,  8, 0, 0);
      run_case("R3",   4, 3, 0, 0, 0, 1, 0, 44, 44, 16, 1, 0);
      run_case("R4",   8, 1, 1, 0, 0, 1, 0, 60, 60,  0, 1, 0);
      run_case("R4",   5, 2, 1, 0, 0, 1, 0, 56, 56, 20, 0, 0);
      run_case("R5",   6, 1, 0, 1, 0, 0, 0, 20, 21, 32, 1, 0);
      run_case("R5",   4, 2, 1, 1, 0, 1, 0, 62, 62,  4, 0, 0);
      run_case("R5",   3, 1, 0, 1, 0, 1, 0, 48, 48,  8, 0, 0);
      run_case("R6",   4, 3, 0, 0, 1, 0, 0, 24,  0, 36, 1, 0);
      run_case("R6",   3, 4, 0, 1, 1, 1, 0, 10,  0, 50, 0, 0);
      run_case("R6",   5, 1, 0, 0, 1, 0, 0, 14,  5, 40, 0, 0);
      run_case("R11",  4, 2, 0, 0, 0, 0, 1, 34,  6, 44, 1, 0);
      run_case("R7",   0, 2, 1, 0, 0, 1, 0,  1,  1,  2, 0, 0);
      run_case("R10",  6, 2, 0, 0, 0, 0, 0,  0, 16, 28, 0, 1);
      run_case("R2",  15, 4, 0, 0, 0, 0, 0, 40, 20,  3, 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule